// File: doc/BRIEF.md
# DMA Channel Address and Count Registers

This block holds the address and transfer-count state for a single DMA channel. Each of the two quantities has a working (current) copy, which the channel steps as transfers happen, and a saved (base) copy, which keeps the value the host last programmed. The host programs both copies through one byte-wide port. An internal byte pointer picks the low byte on the first access and the high byte on the next. A separate command puts the pointer back to the low byte.

Each transfer strobe moves the working address up or down by one, as a mode input selects, and lowers the working count by one. The step that takes the count from zero to all ones is the terminal count, and it raises a one-clock flag. An end-of-process event reloads both working registers from their saved copies, but only when auto-reload is enabled. That event is either the terminal count or an external end-of-process pulse. With auto-reload off, the count stays wrapped at all ones. Readback shows only the working registers.

Top module: `dma_chan_regs`

## Requirements
- R1: Synchronous active-high reset clears the working and saved registers, the byte pointer, `rdata`, `tc` and `eop_out` to zero.
- R2: A `host_wr` cycle writes `host_wdata` into the byte picked by the byte pointer (0 = bits 7:0, 1 = bits 15:8) of both the saved and the working copy of the register picked by `host_sel` (0 = address, 1 = count). After the edge the pointer moves to the other byte.
- R3: A `host_rd` cycle puts the pointed-to byte of the selected working register on `rdata` after the clock edge and advances the pointer. Saved registers are never visible on `rdata`.
- R4: `ptr_clr` returns the byte pointer to the low byte. A `ptr_clr` issued after a single write makes the next write land in bits 7:0 again.
- R5: A `step` cycle lowers the working count by one. It also moves the working address by +1 (`addr_dec`=0) or -1 (`addr_dec`=1), modulo 2^16. With no step, host write or end-of-process, both hold.
- R6: A step taken while the working count is 0000h raises `tc` and `eop_out` for exactly the following clock.
- R7: With `autoinit`=0, the terminal step leaves the count at FFFFh and steps the address normally. Later steps continue down from FFFFh.
- R8: With `autoinit`=1, the terminal step loads the working address and count from their saved copies instead of stepping. The saved copies do not change.
- R9: An `eop_in` pulse drives `eop_out` high on the next clock. It reloads both working registers from the saved copies when `autoinit`=1, and leaves them unchanged when `autoinit`=0.
- R10: In a `host_wr` cycle, `step` and `eop_in` have no effect on the working registers. Only the written byte changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host byte write strobe |
| host_rd | input | 1 | Host byte read strobe |
| host_sel | input | 1 | Register select: 0 address, 1 count |
| host_wdata | input | 8 | Host write byte |
| ptr_clr | input | 1 | Return byte pointer to low byte |
| step | input | 1 | One transfer completed |
| addr_dec | input | 1 | 1 = decrement address per step |
| autoinit | input | 1 | 1 = reload on end-of-process |
| eop_in | input | 1 | External end-of-process pulse |
| cur_addr | output | 16 | Working address |
| cur_cnt | output | 16 | Working count |
| tc | output | 1 | Terminal-count pulse |
| eop_out | output | 1 | End-of-process pulse |
| rdata | output | 8 | Readback byte, registered |

## Verification
The hardest case to reach is a terminal step when the saved values differ from the working ones. Only there do an auto-reload and a plain wrap give different results. The bench programs small counts (0 to 3) and addresses next to 0000h and FFFFh. It then steps each channel through terminal count in every combination of direction and auto-reload. After wrapping it reads back the working registers and compares them with the arithmetic model. This shows that the saved copies never reach `rdata` and that a reload restores the programmed values.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic {
    SEL_ADDR = 1'b0,
    SEL_CNT  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr #(
  parameter int NB = 2,
  parameter int PW = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  output logic [PW-1:0] ptr
);
  localparam logic [PW-1:0] LAST = PW'(NB - 1);

  always_ff @(posedge clk) begin
    if (rst || clr)  ptr <= '0;
    else if (adv)    ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  AST_PTR_CLR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (ptr == '0)); // R4
endmodule

// File: rtl/dma_reg_pair.sv
module dma_reg_pair #(
  parameter int W  = 16,
  parameter int DW = 8,
  parameter int NB = 2,
  parameter int PW = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  logic [DW-1:0] wr_byte,
  input  logic          step_en,
  input  logic          step_dn,
  input  logic          reload,
  output logic [W-1:0]  base_q,
  output logic [W-1:0]  cur_q
);
  logic [W-1:0] cur_wr;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)                              base_q[b*DW +: DW] <= '0;
      else if (wr_en && wr_idx == PW'(b))   base_q[b*DW +: DW] <= wr_byte;
    end
  end

  always_comb begin
    cur_wr = cur_q;
    for (int b = 0; b < NB; b++)
      if (wr_idx == PW'(b)) cur_wr[b*DW +: DW] = wr_byte;
  end

  always_ff @(posedge clk) begin
    if (rst)           cur_q <= '0;
    else if (wr_en)    cur_q <= cur_wr;
    else if (reload)   cur_q <= base_q;
    else if (step_en)  cur_q <= step_dn ? cur_q - 1'b1 : cur_q + 1'b1;
  end

  AST_BASE_FIXED: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(base_q)); // R8
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int DW = 8,
  parameter int W  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic          host_sel,
  input  logic [DW-1:0] host_wdata,
  input  logic          ptr_clr,
  input  logic          step,
  input  logic          addr_dec,
  input  logic          autoinit,
  input  logic          eop_in,
  output logic [W-1:0]  cur_addr,
  output logic [W-1:0]  cur_cnt,
  output logic          tc,
  output logic          eop_out,
  output logic [DW-1:0] rdata
);
  localparam int NB = W / DW;
  localparam int PW = (NB > 1) ? $clog2(NB) : 1;

  reg_sel_e       sel;
  logic [PW-1:0]  ptr;
  logic [W-1:0]   base_addr, base_cnt;
  logic           wr_addr, wr_cnt, step_en, term, reload;
  logic [W-1:0]   rd_src;
  logic [DW-1:0]  rd_byte;

  assign sel     = reg_sel_e'(host_sel);
  assign wr_addr = host_wr && (sel == SEL_ADDR);
  assign wr_cnt  = host_wr && (sel == SEL_CNT);
  assign step_en = step && !host_wr;
  assign term    = step_en && (cur_cnt == '0);
  assign reload  = autoinit && !host_wr && (eop_in || term);

  dma_byte_ptr #(.NB(NB), .PW(PW)) u_ptr (
    .clk(clk), .rst(rst), .clr(ptr_clr), .adv(host_wr || host_rd), .ptr(ptr)
  );

  dma_reg_pair #(.W(W), .DW(DW), .NB(NB), .PW(PW)) u_addr (
    .clk(clk), .rst(rst), .wr_en(wr_addr), .wr_idx(ptr), .wr_byte(host_wdata),
    .step_en(step_en), .step_dn(addr_dec), .reload(reload),
    .base_q(base_addr), .cur_q(cur_addr)
  );

  dma_reg_pair #(.W(W), .DW(DW), .NB(NB), .PW(PW)) u_cnt (
    .clk(clk), .rst(rst), .wr_en(wr_cnt), .wr_idx(ptr), .wr_byte(host_wdata),
    .step_en(step_en), .step_dn(1'b1), .reload(reload),
    .base_q(base_cnt), .cur_q(cur_cnt)
  );

  assign rd_src = (sel == SEL_CNT) ? cur_cnt : cur_addr;

  always_comb begin
    rd_byte = '0;
    for (int b = 0; b < NB; b++)
      if (ptr == PW'(b)) rd_byte = rd_src[b*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      tc      <= 1'b0;
      eop_out <= 1'b0;
    end else begin
      if (host_rd) rdata <= rd_byte;
      tc      <= term;
      eop_out <= term || eop_in;
    end
  end

  AST_TC_ROLL: assert property (@(posedge clk) disable iff (rst)
    tc |-> ($past(step && !host_wr) && $past(cur_cnt) == '0)); // R6
  AST_WRAP_NOAUTO: assert property (@(posedge clk) disable iff (rst)
    (step && !host_wr && !autoinit && cur_cnt == '0) |=> (cur_cnt == '1 && tc)); // R7
  AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (autoinit && !host_wr && (eop_in || (step && cur_cnt == '0)))
      |=> (cur_cnt == $past(base_cnt) && cur_addr == $past(base_addr))); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!host_wr && !step && !eop_in) |=> ($stable(cur_cnt) && $stable(cur_addr))); // R5
  AST_ADDR_UP: assert property (@(posedge clk) disable iff (rst)
    (step && !host_wr && !addr_dec && !autoinit) |=> (cur_addr == $past(cur_addr) + 1'b1)); // R5
endmodule

// File: tb/sim_dma_chan_regs.sv
module sim_dma_chan_regs;
  logic        clk = 1'b0;
  logic        rst, host_wr, host_rd, host_sel, ptr_clr, step, addr_dec, autoinit, eop_in;
  logic [7:0]  host_wdata;
  logic [15:0] cur_addr, cur_cnt;
  logic        tc, eop_out;
  logic [7:0]  rdata;

  int errs = 0, total = 0;
  logic [15:0] m_addr, m_cnt, m_baddr, m_bcnt;

  always #5 clk = ~clk;

  dma_chan_regs u0 (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel),
    .host_wdata(host_wdata), .ptr_clr(ptr_clr), .step(step), .addr_dec(addr_dec),
    .autoinit(autoinit), .eop_in(eop_in), .cur_addr(cur_addr), .cur_cnt(cur_cnt),
    .tc(tc), .eop_out(eop_out), .rdata(rdata)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic idle();
    host_wr = 0; host_rd = 0; ptr_clr = 0; step = 0; eop_in = 0;
  endtask

  task automatic clr_ptr();
    ptr_clr = 1; @(negedge clk); idle();
  endtask

  task automatic wr_byte(input logic s, input logic [7:0] d);
    host_wr = 1; host_sel = s; host_wdata = d; @(negedge clk); idle();
  endtask

  task automatic write16(input logic s, input logic [15:0] v);
    clr_ptr();
    wr_byte(s, v[7:0]);
    wr_byte(s, v[15:8]);
    if (s) begin m_cnt = v; m_bcnt = v; end
    else   begin m_addr = v; m_baddr = v; end
  endtask

  task automatic read16(input logic s, input string rq);
    logic [15:0] e;
    e = s ? m_cnt : m_addr;
    clr_ptr();
    host_rd = 1; host_sel = s; @(negedge clk); idle();
    chk(rq, rdata, e[7:0]);
    host_rd = 1; host_sel = s; @(negedge clk); idle();
    chk(rq, rdata, e[15:8]);
  endtask

  task automatic step_chk(input string rq);
    logic t;
    t = (m_cnt == 16'h0000);
    if (t && autoinit) begin
      m_addr = m_baddr; m_cnt = m_bcnt;
    end else begin
      m_cnt  = m_cnt - 16'd1;
      m_addr = addr_dec ? m_addr - 16'd1 : m_addr + 16'd1;
    end
    step = 1; @(negedge clk); idle();
    chk(rq, cur_cnt, m_cnt);
    chk(rq, cur_addr, m_addr);
    chk("R6 tc", tc, t);
    chk("R6 eop_out", eop_out, t);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

  initial begin
    idle(); host_sel = 0; host_wdata = 0; addr_dec = 0; autoinit = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 addr", cur_addr, 0); chk("R1 cnt", cur_cnt, 0);
    chk("R1 tc", tc, 0); chk("R1 eop", eop_out, 0); chk("R1 rdata", rdata, 0);
    m_addr = 0; m_cnt = 0; m_baddr = 0; m_bcnt = 0;

    // R4: pointer clear after one byte sends next write to low byte
    write16(0, 16'h1234);
    wr_byte(0, 8'hAB);
    clr_ptr();
    wr_byte(0, 8'hCD);
    m_addr = 16'h12CD; m_baddr = 16'h12CD;
    chk("R4 ptr_clr", cur_addr, 16'h12CD);

    // R10: step and eop_in ignored during host write
    write16(1, 16'h0005);
    autoinit = 1;
    clr_ptr();
    host_wr = 1; host_sel = 0; host_wdata = 8'h77; step = 1; eop_in = 1;
    @(negedge clk); idle();
    m_addr = 16'h1277; m_baddr = 16'h1277;
    chk("R10 addr", cur_addr, 16'h1277);
    chk("R10 cnt", cur_cnt, 16'h0005);
    autoinit = 0;

    // R5 hold with no activity
    repeat (2) @(negedge clk);
    chk("R5 hold cnt", cur_cnt, m_cnt);
    chk("R5 hold addr", cur_addr, m_addr);

    // Sweep: direction x autoinit x small counts, addresses at wrap edges
    for (int dec = 0; dec < 2; dec++) begin
      for (int ai = 0; ai < 2; ai++) begin
        for (int n = 0; n < 4; n++) begin
          addr_dec = dec[0]; autoinit = ai[0];
          write16(0, dec ? 16'h0001 + 16'(n) : 16'hFFFE - 16'(n));
          write16(1, 16'(n));
          chk("R2 addr load", cur_addr, m_addr);
          chk("R2 cnt load", cur_cnt, m_cnt);
          read16(0, "R3 addr readback");
          read16(1, "R3 cnt readback");
          for (int k = 0; k <= n + 1; k++) begin
            if (m_cnt == 0) step_chk(ai ? "R8 reload at tc" : "R7 wrap at tc");
            else            step_chk("R5 step");
          end
          read16(1, "R3 cnt after tc (base hidden)");
          read16(0, "R3 addr after tc");
          // R9 external end-of-process
          step_chk("R5 step before eop");
          eop_in = 1; @(negedge clk); idle();
          if (ai) begin m_addr = m_baddr; m_cnt = m_bcnt; end
          chk("R9 eop cnt", cur_cnt, m_cnt);
          chk("R9 eop addr", cur_addr, m_addr);
          chk("R9 eop_out", eop_out, 1);
          chk("R6 tc not on eop_in", tc, 0);
          @(negedge clk);
          chk("R6 eop_out one clock", eop_out, 0);
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule